// File: doc/BRIEF.md
# Single-Register Load/Store Data Path

This unit carries out one-register memory transfers for a 32-bit core whose byte address space is 26 bits wide (64 MiB). Upstream logic presents a decoded request with the following fields:

- transfer direction: load or store;
- size: full word or single byte;
- a flag that forces user privilege for this one access;
- the current-mode privilege;
- the computed byte address;
- the source register value for stores.

The unit registers the request and issues it to a simple synchronous memory port for exactly one cycle. That cycle carries the address, write enable, per-byte lane enables, write data and a privilege bit.

For loads, the unit waits for the memory read response. It then returns the data already shaped for the register file: the whole word for word loads, or the addressed byte zero-extended for byte loads. The result comes with a one-cycle valid pulse. A byte store repeats the low byte of the source on every lane and enables only the lane that the low address bits name, so the other bytes of the word are left untouched.

The forced-user flag makes that single access run with user privilege, whatever the current mode is. The unit does not compute addresses, evaluate conditions or write back registers.

Top module: `ldst_single_unit`

## Requirements
- R1: The memory address is 26 bits. A byte access presents the request address unchanged. A word access presents it with bits 1:0 cleared.
- R2: A word load returns the full 32-bit memory word on `res_data`.
- R3: A byte load returns the byte selected by address bits 1:0, zero-extended to 32 bits. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: A byte store asserts only `mem_be[addr[1:0]]` and repeats source bits 7:0 on all four lanes of `mem_wdata`. The other bytes of the memory word keep their values.
- R5: A word store asserts all four bits of `mem_be` and drives the full 32-bit source value on `mem_wdata`.
- R6: `mem_priv` (1 = privileged, 0 = user) equals the request's `cur_priv` unless `req_force_user` is 1, in which case it is 0. The override applies to that access only.
- R7: `req_ready` is high only while the unit is idle. A request is taken only when `req_valid` and `req_ready` are both high. `mem_req` is high for exactly the one cycle after acceptance. Requests presented while the unit is busy are ignored.
- R8: For a load, `res_valid` pulses for one cycle, in the cycle after the one where `mem_rvalid` is sampled high while waiting. A store never raises `res_valid`.
- R9: During and right after reset, `req_ready` is 1 and `mem_req`, `mem_we`, `mem_be` and `res_valid` are 0.
- R10: A `mem_rvalid` pulse while no load is waiting has no effect on `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_is_byte | input | 1 | 1 = byte, 0 = word |
| req_force_user | input | 1 | Run this access with user privilege |
| cur_priv | input | 1 | Current-mode privilege (1 = privileged) |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 32 | Store source value |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 26 | Memory byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_priv | output | 1 | Access privilege (1 = privileged, 0 = user) |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| res_valid | output | 1 | Load result valid pulse |
| res_data | output | 32 | Formatted load result |

## Verification
Word stores first fill eight words with distinct patterns. Byte stores are then swept over every lane, together with all four combinations of current privilege and forced-user flag. Word loads read the result back to show that only the addressed byte changed and that the replication lands in the right lane. Byte loads over every lane and word index separate a wrong lane select from a missing zero extension. Word accesses with nonzero low address bits, read latencies of zero to three cycles, requests held high while busy, and stray read responses while idle each tell apart faults in address alignment, the wait handshake and the acceptance gating.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      LS_IDLE  = 2'd0,
      LS_ISSUE = 2'd1,
      LS_WAIT  = 2'd2
   } ldst_state_e;

   localparam logic PRIV_USER = 1'b0;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
   import ldst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic q_store,
   input  logic mem_rvalid,
   output logic req_ready,
   output logic accept,
   output logic issue,
   output logic capture
);

   ldst_state_e state_q, state_d;

   assign req_ready = (state_q == LS_IDLE);
   assign accept    = req_ready & req_valid;
   assign issue     = (state_q == LS_ISSUE);
   assign capture   = (state_q == LS_WAIT) & mem_rvalid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LS_IDLE:  if (accept) state_d = LS_ISSUE;
         LS_ISSUE: state_d = q_store ? LS_IDLE : LS_WAIT;
         LS_WAIT:  if (mem_rvalid) state_d = LS_IDLE;
         default:  state_d = LS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LS_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/ldst_lane_steer.sv
module ldst_lane_steer #(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic              en,
   input  logic              is_byte,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata
);

   logic [SEL_W-1:0]  lane;
   logic [LANES-1:0]  be_raw;
   logic [DATA_W-1:0] wdata_rep;
   logic [ADDR_W-1:0] addr_aligned;

   assign lane         = addr[SEL_W-1:0];
   assign addr_aligned = {addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be_raw[g] = is_byte ? (lane == SEL_W'(g)) : 1'b1;
      assign wdata_rep[g*LANE_W +: LANE_W] =
         is_byte ? wdata[LANE_W-1:0] : wdata[g*LANE_W +: LANE_W];
   end

   assign mem_be    = en ? be_raw    : '0;
   assign mem_wdata = en ? wdata_rep : '0;
   assign mem_addr  = en ? (is_byte ? addr : addr_aligned) : '0;

endmodule

// File: rtl/ldst_load_format.sv
module ldst_load_format #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic              is_byte,
   input  logic [SEL_W-1:0]  lane,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);

   logic [LANE_W-1:0] lane_bytes [LANES];
   logic [LANE_W-1:0] picked;

   for (genvar g = 0; g < LANES; g++) begin : g_split
      assign lane_bytes[g] = rdata[g*LANE_W +: LANE_W];
   end

   assign picked = lane_bytes[lane];
   assign result = is_byte ? {{(DATA_W-LANE_W){1'b0}}, picked} : rdata;

endmodule

// File: rtl/ldst_single_unit.sv
module ldst_single_unit
   import ldst_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_store,
   input  logic              req_is_byte,
   input  logic              req_force_user,
   input  logic              cur_priv,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_priv,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data
);

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("DATA_W must be a whole number of lanes");
   end
   if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
      $error("lane count must be a power of two of at least 2");
   end
   if (ADDR_W <= SEL_W) begin : g_bad_addr
      $error("ADDR_W too small for lane select");
   end

   logic              accept, issue, capture;
   logic              q_store, q_byte, q_priv;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic [DATA_W-1:0] fmt_data;

   ldst_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .q_store    (q_store),
      .mem_rvalid (mem_rvalid),
      .req_ready  (req_ready),
      .accept     (accept),
      .issue      (issue),
      .capture    (capture)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_store <= 1'b0;
         q_byte  <= 1'b0;
         q_priv  <= PRIV_USER;
         q_addr  <= '0;
         q_wdata <= '0;
      end else if (accept) begin
         q_store <= req_is_store;
         q_byte  <= req_is_byte;
         q_priv  <= req_force_user ? PRIV_USER : cur_priv;
         q_addr  <= req_addr;
         q_wdata <= req_wdata;
      end
   end

   ldst_lane_steer #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_steer (
      .en        (issue),
      .is_byte   (q_byte),
      .addr      (q_addr),
      .wdata     (q_wdata),
      .mem_addr  (mem_addr),
      .mem_be    (mem_be),
      .mem_wdata (mem_wdata)
   );

   assign mem_req  = issue;
   assign mem_we   = issue & q_store;
   assign mem_priv = q_priv;

   ldst_load_format #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_fmt (
      .is_byte (q_byte),
      .lane    (q_addr[SEL_W-1:0]),
      .rdata   (mem_rdata),
      .result  (fmt_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= capture;
         if (capture) res_data <= fmt_data;
      end
   end

endmodule

// File: rtl/ldst_single_unit_chk.sv
module ldst_single_unit_chk #(
   parameter int ADDR_W = 26,
   parameter int LANES  = 4,
   localparam int SEL_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_force_user,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LANES-1:0]  mem_be,
   input logic              mem_priv,
   input logic              mem_rvalid,
   input logic              res_valid
);

   assert_accept_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> mem_req);

   assert_issue_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_result_follows_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(mem_rvalid));

   assert_lane_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || mem_be == {LANES{1'b1}}));

   assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $countones(mem_be) == 1) |-> mem_be[mem_addr[SEL_W-1:0]]);

   assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_be == {LANES{1'b1}}) |-> (mem_addr[SEL_W-1:0] == '0));

   assert_force_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_force_user) |=> (mem_req && !mem_priv));

   assert_quiet_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (!mem_we && mem_be == '0));

endmodule

bind ldst_single_unit ldst_single_unit_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_force_user (req_force_user),
   .mem_req        (mem_req),
   .mem_we         (mem_we),
   .mem_addr       (mem_addr),
   .mem_be         (mem_be),
   .mem_priv       (mem_priv),
   .mem_rvalid     (mem_rvalid),
   .res_valid      (res_valid)
);

// File: tb/ldst_single_unit_bench.sv
module ldst_single_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [25:0] BASE = 26'h2B5C0E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_is_store = 1'b0;
   logic        req_is_byte = 1'b0;
   logic        req_force_user = 1'b0;
   logic        cur_priv = 1'b0;
   logic [25:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_we, mem_priv;
   logic [25:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        res_valid;
   logic [31:0] res_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] bmem [8];
   logic [31:0] emem [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   ldst_single_unit u_ldst_single_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_is_store(req_is_store), .req_is_byte(req_is_byte),
      .req_force_user(req_force_user), .cur_priv(cur_priv),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_priv(mem_priv),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .res_valid(res_valid), .res_data(res_data)
   );

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         for (int i = 0; i < 4; i++)
            if (mem_be[i]) bmem[mem_addr[4:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input bit st, input bit by, input bit fu, input bit cp,
                         input logic [25:0] a, input logic [31:0] wd,
                         input int lat, input bit busy_poke);
      logic [2:0]  idx;
      logic [1:0]  ln;
      logic [31:0] exp_res;
      logic [3:0]  exp_be;
      logic [31:0] exp_wd;
      idx = a[4:2];
      ln  = a[1:0];
      @(negedge clk);
      check("R7 ready when idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_is_store = st; req_is_byte = by;
      req_force_user = fu; cur_priv = cp; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = busy_poke;
      if (busy_poke) begin
         req_is_store = 1'b1; req_is_byte = 1'b0; req_force_user = 1'b0;
         req_addr = BASE; req_wdata = 32'hDEAD_BEEF;
      end
      exp_be = by ? (4'b0001 << ln) : 4'b1111;
      exp_wd = by ? {4{wd[7:0]}} : wd;
      check("R7 mem_req after accept", {31'd0, mem_req}, 32'd1);
      check("R7 not ready while busy", {31'd0, req_ready}, 32'd0);
      check(st ? "R5 write enable" : "R2 no write on load", {31'd0, mem_we}, {31'd0, st});
      check("R1 address", {6'd0, mem_addr}, {6'd0, by ? a : {a[25:2], 2'b00}});
      check(by ? "R4 lane enable" : "R5 all lanes", {28'd0, mem_be}, {28'd0, exp_be});
      if (st) check(by ? "R4 replicated data" : "R5 word data", mem_wdata, exp_wd);
      check("R6 privilege", {31'd0, mem_priv}, {31'd0, fu ? 1'b0 : cp});
      if (st) begin
         for (int i = 0; i < 4; i++)
            if (exp_be[i]) emem[idx][i*8 +: 8] = exp_wd[i*8 +: 8];
         @(negedge clk);
         req_valid = 1'b0;
         check("R7 strobe one cycle", {31'd0, mem_req}, 32'd0);
         check("R8 no result on store", {31'd0, res_valid}, 32'd0);
      end else begin
         @(negedge clk);
         check("R7 single strobe on load", {31'd0, mem_req}, 32'd0);
         for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            check("R7 busy request ignored", {31'd0, mem_req}, 32'd0);
            check("R8 no early result", {31'd0, res_valid}, 32'd0);
         end
         mem_rvalid = 1'b1;
         mem_rdata  = bmem[idx];
         @(negedge clk);
         mem_rvalid = 1'b0;
         mem_rdata  = 32'h0;
         req_valid  = 1'b0;
         exp_res = by ? ((emem[idx] >> (8 * ln)) & 32'hFF) : emem[idx];
         check("R8 result pulse", {31'd0, res_valid}, 32'd1);
         check(by ? "R3 byte zero extend" : "R2 word load", res_data, exp_res);
         @(negedge clk);
         check("R8 result one cycle", {31'd0, res_valid}, 32'd0);
         check("R7 no busy request accepted", {31'd0, mem_req}, 32'd0);
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         bmem[i] = 32'h0;
         emem[i] = 32'h0;
      end
      repeat (2) @(negedge clk);
      check("R9 ready in reset", {31'd0, req_ready}, 32'd1);
      check("R9 no strobe", {31'd0, mem_req}, 32'd0);
      check("R9 no write", {31'd0, mem_we}, 32'd0);
      check("R9 lanes off", {28'd0, mem_be}, 32'd0);
      check("R9 no result", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 ready after reset", {31'd0, req_ready}, 32'd1);
      check("R9 no strobe after reset", {31'd0, mem_req}, 32'd0);

      for (int i = 0; i < 8; i++)
         access(1, 0, i[0], i[1], BASE | 26'(i * 4 + (i % 4)),
                32'h1357_9BDF ^ (32'(i) * 32'h0102_0304), 0, 0);
      for (int i = 0; i < 8; i++)
         access(0, 0, 0, 1, BASE | 26'(i * 4 + 3), 32'h0, i % 4, 0);

      for (int i = 0; i < 8; i++)
         for (int ln = 0; ln < 4; ln++)
            access(1, 1, ln[0], ln[1], BASE | 26'(i * 4 + ln),
                   {24'hFFFF_FF, 8'(8'hA0 + i * 4 + ln)} ^ 32'h5500_0000, 0, 0);
      for (int i = 0; i < 8; i++)
         access(0, 0, i[0], 1, BASE | 26'(i * 4), 32'h0, 1, 0);

      for (int i = 0; i < 2; i++)
         access(1, 1, 0, 1, BASE | 26'(i * 4 + 2), 32'h0000_0080, 0, 0);
      for (int i = 0; i < 8; i++)
         for (int ln = 0; ln < 4; ln++)
            access(0, 1, ln[1], ln[0], BASE | 26'(i * 4 + ln), 32'h0, (i + ln) % 4, 0);

      access(0, 0, 0, 1, BASE | 26'd20, 32'h0, 2, 1);
      access(0, 0, 0, 1, BASE, 32'h0, 0, 0);
      access(1, 0, 1, 1, BASE | 26'd8, 32'hCAFE_F00D, 0, 1);
      @(negedge clk);
      req_valid = 1'b0;
      access(0, 0, 0, 0, BASE | 26'd8, 32'h0, 0, 0);
      access(0, 0, 0, 0, BASE, 32'h0, 0, 0);

      @(negedge clk);
      mem_rvalid = 1'b1;
      mem_rdata  = 32'h7777_7777;
      @(negedge clk);
      mem_rvalid = 1'b0;
      check("R10 stray response ignored", {31'd0, res_valid}, 32'd0);
      @(negedge clk);
      check("R10 still no result", {31'd0, res_valid}, 32'd0);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule